// File: doc/BRIEF.md
# Eight-Bit Compare Timer

An 8-bit timer with one compare register and one waveform output pin, driven from a small register bus. A single control byte selects one of four counting modes, the action taken on the output pin when the count equals the compare value, and a clock-enable divider for the count. The modes are free-running, clear-on-compare (CTC), single-slope PWM and dual-slope (phase-correct) PWM.

Software writes the control, count and compare registers and reads them back one cycle later. The compare flag and the overflow flag are also brought out as pins so that an interrupt controller outside the block can use them. A force strobe in the control byte applies the compare action to the pin at once, without the side effects of a real match. In the PWM modes the compare register is double-buffered so that the duty cycle changes only at the top of the count.

Top module: `wavetimer8`

## Requirements
- R1: After a synchronous active-high reset, all four registers read as 0x00, `wave_out`, `cmp_flag` and `ovf_flag` are low, and the counter is stopped.
- R2: Control bits [2:0] choose the count enable: 000, 110 and 111 stop the counter; 001 advances it on every clock; 010, 011, 100 and 101 advance it once every 8, 64, 256 and 1024 clocks.
- R3: Mode {ctrl[3],ctrl[6]} = 00 counts up from 0 to 255 and wraps to 0. The wrap sets `ovf_flag` (flag register bit 1).
- R4: Mode 10 (CTC) counts up to the compare value, then returns to 0 on the next count enable. The match sets `cmp_flag` (flag register bit 0).
- R5: In modes 00 and 10, control bits [5:4] give the action on a match: 01 toggles the pin, 10 drives it low, 11 drives it high. 00 holds `wave_out` low.
- R6: Writing the control register with bit 7 set, in a non-PWM mode, applies the bits [5:4] action to the pin on that same edge. It sets no flag and does not change the count.
- R7: Bit 7 of the control register always reads back as 0. Bits 6:0 read back as written.
- R8: In the PWM modes (01 and 11), writing bit 7 has no effect on the pin.
- R9: Mode 11 (fast PWM) counts 0 to 255 and wraps. With bits [5:4] = 10, the pin goes high at the wrap and low at the compare match. With 11, the pin goes low at the wrap and high at the match. The wrap sets `ovf_flag`.
- R10: Mode 01 (phase-correct PWM) counts up to 255 and then down to 0. `ovf_flag` sets when the count turns at 0. With bits [5:4] = 10, the pin goes low at a match while counting up and high at a match while counting down.
- R11: In the PWM modes, a compare write is held in a buffer that takes effect when the count is at 255. In the other modes it takes effect at once. The compare register always reads back the last value written.
- R12: Register addresses are 0 control, 1 count, 2 compare and 3 flags. Writing a 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A flag event in the same cycle wins over the clear.
- R13: A write to the count register loads the counter, and this load takes priority over a count enable in the same cycle. A read returns the register value on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 count, 2 compare, 3 flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address presented before the edge |
| wave_out | output | 1 | Compare waveform output |
| cmp_flag | output | 1 | Compare match flag |
| ovf_flag | output | 1 | Overflow / bottom flag |

## Verification
A control write that selects an undivided count enable takes effect on its own edge E. The first increment therefore lands on edge E+1, and a flag or pin change caused by the count reaching value v shows up on the edge after the counter holds v. Force actions and write-one-to-clear flag updates appear on the edge of the write itself. Register reads show data on the edge after the address. The bench counts edges from each write with one task per scenario. It samples the pins on the falling edge just before and just after the edge where a change is due, so both an early and a late change are caught. Prescaler ratios are checked by counting ticks over a window that is a whole multiple of the ratio, so the check does not depend on the divider's phase.

// File: rtl/wt8_pkg.sv
package wt8_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PHASE  = 2'b01,
    MODE_CTC    = 2'b10,
    MODE_FAST   = 2'b11
  } wave_mode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CMP   = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;

  // control byte field positions (decoded by software, so fixed)
  localparam int CTRL_FORCE_B = 7;
  localparam int CTRL_MODE0_B = 6;
  localparam int CTRL_COM_HI  = 5;
  localparam int CTRL_COM_LO  = 4;
  localparam int CTRL_MODE1_B = 3;
  localparam int CTRL_CS_HI   = 2;

  localparam int FLAG_CMP_B = 0;
  localparam int FLAG_OVF_B = 1;

  function automatic wave_mode_e mode_of(input logic [7:0] ctrl);
    return wave_mode_e'({ctrl[CTRL_MODE1_B], ctrl[CTRL_MODE0_B]});
  endfunction

  function automatic logic is_pwm(input wave_mode_e m);
    return (m == MODE_PHASE) || (m == MODE_FAST);
  endfunction

endpackage

// File: rtl/wt8_prescale.sv
module wt8_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel,
  output logic       tick
);
  localparam int DIV8_B    = 3;
  localparam int DIV64_B   = 6;
  localparam int DIV256_B  = 8;
  localparam int DIV1024_B = (PRE_W < 10) ? PRE_W : 10;

  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  always_comb begin
    case (clk_sel)
      3'b001:  tick = 1'b1;
      3'b010:  tick = &div_q[DIV8_B-1:0];
      3'b011:  tick = &div_q[DIV64_B-1:0];
      3'b100:  tick = &div_q[DIV256_B-1:0];
      3'b101:  tick = &div_q[DIV1024_B-1:0];
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/wt8_counter.sv
module wt8_counter
  import wt8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wave_mode_e       mode,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_buf_q,
  output logic [CNT_W-1:0] cmp_act_q,
  output logic             dir_up_q,
  output logic             match_evt,
  output logic             bottom_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             adv;
  logic [CNT_W-1:0] cnt_nxt;
  logic             dir_nxt;
  logic             top_load;
  logic             at_max;
  logic             at_zero;

  assign adv     = tick && !cnt_we;
  assign at_max  = (cnt_q == CNT_MAX);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_nxt    = cnt_q + 1'b1;
    dir_nxt    = 1'b1;
    top_load   = 1'b0;
    bottom_evt = 1'b0;
    match_evt  = adv && (cnt_q == cmp_act_q);
    case (mode)
      MODE_NORMAL: begin
        bottom_evt = adv && at_max;
      end
      MODE_CTC: begin
        if (cnt_q == cmp_act_q) cnt_nxt = '0;
        bottom_evt = adv && at_max;
      end
      MODE_FAST: begin
        bottom_evt = adv && at_max;
        top_load   = adv && at_max;
      end
      default: begin
        if (dir_up_q) begin
          if (at_max) begin
            cnt_nxt  = CNT_MAX - 1'b1;
            dir_nxt  = 1'b0;
            top_load = adv;
          end
        end else begin
          if (at_zero) begin
            cnt_nxt    = CNT_ONE;
            dir_nxt    = 1'b1;
            bottom_evt = adv;
          end else begin
            cnt_nxt = cnt_q - 1'b1;
            dir_nxt = 1'b0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else begin
      if (cnt_we) begin
        cnt_q <= wdata;
      end else if (adv) begin
        cnt_q <= cnt_nxt;
        if (mode == MODE_PHASE) dir_up_q <= dir_nxt;
      end
      if (mode != MODE_PHASE) dir_up_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
    end else begin
      if (cmp_we) begin
        cmp_buf_q <= wdata;
        if (!is_pwm(mode)) cmp_act_q <= wdata;
      end else if (top_load || !is_pwm(mode)) begin
        cmp_act_q <= cmp_buf_q;
      end
    end
  end
endmodule

// File: rtl/wt8_wavegen.sv
module wt8_wavegen
  import wt8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wave_mode_e mode,
  input  logic [1:0] com,
  input  logic       match_evt,
  input  logic       bottom_evt,
  input  logic       count_up,
  input  logic       force_evt,
  output logic       wave_o
);
  logic oc_q;
  logic oc_nxt;

  always_comb begin
    oc_nxt = oc_q;
    case (mode)
      MODE_FAST: begin
        if (com[1]) begin
          if (bottom_evt)     oc_nxt = !com[0];
          else if (match_evt) oc_nxt = com[0];
        end
      end
      MODE_PHASE: begin
        if (com[1] && match_evt) oc_nxt = count_up ? com[0] : !com[0];
      end
      default: begin
        if (match_evt || force_evt) begin
          case (com)
            2'b01:   oc_nxt = !oc_q;
            2'b10:   oc_nxt = 1'b0;
            2'b11:   oc_nxt = 1'b1;
            default: oc_nxt = oc_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q   <= 1'b0;
      wave_o <= 1'b0;
    end else begin
      oc_q   <= oc_nxt;
      wave_o <= (com == 2'b00) ? 1'b0 : oc_nxt;
    end
  end
endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
  import wt8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wave_out,
  output logic              cmp_flag,
  output logic              ovf_flag
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_eff;
  logic              ctrl_wr, cnt_wr, cmp_wr, flag_wr;
  wave_mode_e        mode_q, mode_eff, mode_wr;
  logic              force_evt;
  logic              tick;
  logic [DATA_W-1:0] cnt_q, cmp_buf_q, cmp_act_q;
  logic              dir_up;
  logic              match_evt, bottom_evt;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
  assign cnt_wr  = bus_we && (bus_addr == ADDR_COUNT);
  assign cmp_wr  = bus_we && (bus_addr == ADDR_CMP);
  assign flag_wr = bus_we && (bus_addr == ADDR_FLAGS);

  assign mode_q    = mode_of(ctrl_q);
  assign mode_wr   = mode_of(bus_wdata);
  assign ctrl_eff  = ctrl_wr ? bus_wdata : ctrl_q;
  assign mode_eff  = ctrl_wr ? mode_wr : mode_q;
  assign force_evt = ctrl_wr && bus_wdata[CTRL_FORCE_B] && !is_pwm(mode_wr);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= {1'b0, bus_wdata[CTRL_FORCE_B-1:0]};
  end

  wt8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (ctrl_q[CTRL_CS_HI:0]),
    .tick    (tick)
  );

  wt8_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode       (mode_q),
    .cnt_we     (cnt_wr),
    .cmp_we     (cmp_wr),
    .wdata      (bus_wdata),
    .cnt_q      (cnt_q),
    .cmp_buf_q  (cmp_buf_q),
    .cmp_act_q  (cmp_act_q),
    .dir_up_q   (dir_up),
    .match_evt  (match_evt),
    .bottom_evt (bottom_evt)
  );

  wt8_wavegen u_wave (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_eff),
    .com        (ctrl_eff[CTRL_COM_HI:CTRL_COM_LO]),
    .match_evt  (match_evt),
    .bottom_evt (bottom_evt),
    .count_up   (dir_up),
    .force_evt  (force_evt),
    .wave_o     (wave_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (match_evt)                             cmp_flag <= 1'b1;
      else if (flag_wr && bus_wdata[FLAG_CMP_B]) cmp_flag <= 1'b0;
      if (bottom_evt)                            ovf_flag <= 1'b1;
      else if (flag_wr && bus_wdata[FLAG_OVF_B]) ovf_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_CTRL:  bus_rdata <= ctrl_q;
        ADDR_COUNT: bus_rdata <= cnt_q;
        ADDR_CMP:   bus_rdata <= cmp_buf_q;
        default:    bus_rdata <= {{(DATA_W-2){1'b0}}, ovf_flag, cmp_flag};
      endcase
    end
  end
endmodule

// File: rtl/wt8_checker.sv
module wt8_checker
  import wt8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wave_out,
  input logic              cmp_flag,
  input logic              ovf_flag,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] cmp_act_q,
  input logic              tick,
  input logic              dir_up,
  input logic              match_evt
);
  localparam logic [DATA_W-1:0] CNT_MAX = {DATA_W{1'b1}};

  logic       c_ctrl_wr, c_cnt_wr, stopped;
  wave_mode_e c_mode;

  assign c_ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
  assign c_cnt_wr  = bus_we && (bus_addr == ADDR_COUNT);
  assign c_mode    = mode_of(ctrl_q);
  assign stopped   = (ctrl_q[2:0] == 3'b000) || (ctrl_q[2:0] == 3'b110) || (ctrl_q[2:0] == 3'b111);

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stopped && !c_cnt_wr |=> $stable(cnt_q)); // R2

  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (c_mode == MODE_NORMAL) && tick && (cnt_q == CNT_MAX) && !c_cnt_wr |=> (cnt_q == '0) && ovf_flag); // R3

  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (c_mode == MODE_CTC) && tick && (cnt_q == cmp_act_q) && !c_cnt_wr |=> (cnt_q == '0) && cmp_flag); // R4

  AST_OUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[5:4] == 2'b00) && !c_ctrl_wr |=> !wave_out); // R5

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    c_ctrl_wr && bus_wdata[7] && !cmp_flag && !match_evt |=> !cmp_flag); // R6

  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_CTRL) |=> !bus_rdata[7]); // R7

  AST_PHASE_TURN: assert property (@(posedge clk) disable iff (rst)
    (c_mode == MODE_PHASE) && tick && dir_up && (cnt_q == CNT_MAX) && !c_cnt_wr
      |=> (cnt_q == CNT_MAX - 1'b1) && !dir_up); // R10
endmodule

bind wavetimer8 wt8_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wave_out  (wave_out),
  .cmp_flag  (cmp_flag),
  .ovf_flag  (ovf_flag),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q),
  .cmp_act_q (cmp_act_q),
  .tick      (tick),
  .dir_up    (dir_up),
  .match_evt (match_evt)
);

// File: tb/wavetimer8_test.sv
module wavetimer8_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       wave_out, cmp_flag, ovf_flag;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wavetimer8 uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wave_out(wave_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; wait_edges(2); rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 register reset", v, 8'h00);
    end
    check("R1 pins reset", {wave_out, cmp_flag, ovf_flag}, 3'b000);
  endtask

  task automatic t_normal();
    logic [7:0] v;
    do_reset();
    wr(2'd1, 8'd250);
    wr(2'd0, 8'h01);                 // edge E
    wait_edges(5);
    check("R3 no overflow before wrap", ovf_flag, 1'b0);
    wait_edges(1);
    check("R3 overflow at wrap", ovf_flag, 1'b1);
    wr(2'd3, 8'h02);                 // E+7
    check("R12 write one clears overflow", ovf_flag, 1'b0);
    wr(2'd0, 8'h00);                 // E+8
    rd(2'd1, v);
    check("R13 count after load and run", v, 8'd2);
  endtask

  task automatic t_ctc();
    logic [7:0] v;
    do_reset();
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h19);                 // CTC, toggle, undivided; edge E
    wait_edges(5);
    check("R4 no flag before match", cmp_flag, 1'b0);
    check("R5 toggle not yet", wave_out, 1'b0);
    wait_edges(1);
    check("R4 flag at match", cmp_flag, 1'b1);
    check("R5 toggle high", wave_out, 1'b1);
    wait_edges(6);
    check("R5 toggle low on next match", wave_out, 1'b0);
    wr(2'd0, 8'h39);                 // set on match; E+13, cnt=1
    wait_edges(4);
    check("R5 set not yet", wave_out, 1'b0);
    wait_edges(1);
    check("R5 set on match", wave_out, 1'b1);
    wr(2'd0, 8'h09);                 // output disconnected; E+19
    check("R5 disconnected drives low", wave_out, 1'b0);
    wr(2'd0, 8'h08);                 // stop; E+20
    rd(2'd1, v);
    check("R4 count restarted from zero", v, 8'd2);
  endtask

  task automatic t_force();
    logic [7:0] v;
    do_reset();
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd9);
    wr(2'd0, 8'hB8);                 // force, CTC, set
    check("R6 force sets pin", wave_out, 1'b1);
    check("R6 force raises no flag", cmp_flag, 1'b0);
    rd(2'd1, v);
    check("R6 force keeps count", v, 8'd3);
    rd(2'd0, v);
    check("R7 force bit reads zero", v, 8'h38);
    wr(2'd0, 8'h98);                 // force, CTC, toggle
    check("R6 force toggles pin", wave_out, 1'b0);
    do_reset();
    wr(2'd0, 8'hF8);                 // force in fast PWM, set action
    check("R8 force ignored in PWM", wave_out, 1'b0);
    rd(2'd0, v);
    check("R7 control readback", v, 8'h78);
  endtask

  task automatic t_fast();
    logic [7:0] v;
    do_reset();
    wr(2'd2, 8'h40);
    wr(2'd1, 8'hFC);
    wr(2'd0, 8'h69);                 // fast PWM, clear on match; edge E
    wait_edges(3);
    check("R9 low before wrap", wave_out, 1'b0);
    wait_edges(1);
    check("R9 high at wrap", wave_out, 1'b1);
    check("R9 overflow at wrap", ovf_flag, 1'b1);
    wr(2'd2, 8'h80);                 // E+5, buffered
    wait_edges(8'h3F);
    check("R9 high before match", wave_out, 1'b1);
    wait_edges(1);
    check("R11 old compare used this period", wave_out, 1'b0);
    wait_edges(191);
    check("R9 high at next wrap", wave_out, 1'b1);
    wait_edges(8'h80);
    check("R11 new compare after top", wave_out, 1'b1);
    wait_edges(1);
    check("R11 match at new compare", wave_out, 1'b0);
    rd(2'd2, v);
    check("R11 compare readback", v, 8'h80);
  endtask

  task automatic t_phase();
    logic [7:0] v;
    do_reset();
    wr(2'd2, 8'h10);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h61);                 // phase-correct, clear up / set down; edge E
    wait_edges(240);
    check("R10 low before down match", wave_out, 1'b0);
    wait_edges(1);
    check("R10 high at down match", wave_out, 1'b1);
    wait_edges(15);
    check("R10 no overflow before bottom", ovf_flag, 1'b0);
    wait_edges(1);
    check("R10 overflow at bottom", ovf_flag, 1'b1);
    wait_edges(15);
    check("R10 high before up match", wave_out, 1'b1);
    wait_edges(1);
    check("R10 low at up match", wave_out, 1'b0);
    wr(2'd3, 8'h01);
    check("R12 compare flag cleared", cmp_flag, 1'b0);
    check("R12 overflow flag kept", ovf_flag, 1'b1);
    rd(2'd3, v);
    check("R12 flag register layout", v, 8'h02);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    do_reset();
    wr(2'd0, 8'h02);                 // /8; edge E
    wait_edges(63);
    wr(2'd0, 8'h00);                 // E+64
    rd(2'd1, v);
    check("R2 divide by 8", v, 8'd8);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h03);
    wait_edges(255);
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    check("R2 divide by 64", v, 8'd4);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h06);
    wait_edges(20);
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    check("R2 code 110 stopped", v, 8'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_normal();
    t_ctc();
    t_force();
    t_fast();
    t_phase();
    t_prescale();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule